// File: doc/BRIEF.md
# One-Shot Countdown Event Timer

This block is a single-channel countdown timer for tickless scheduling. Software writes a timeout, in ticks, into a value register. The countdown then starts at once and moves down by one on every clock cycle in which the tick-enable input is high. When the count reaches zero, the counter halts and does not reload. It sets a pending flag, and if interrupts are enabled the level interrupt output goes high. The pending flag is cleared by writing a one to a strobe bit in the control register.

The run bit in the control register gates everything else. While it is clear, writes to the value register are dropped. The interrupt-enable and clear bits of a control write take effect only if the run bit is set in that same write or was already set. Writing zero to the control register while running stops the countdown and turns off the interrupt enable. The counter and pending flag keep their values.

Top module: `oneshot_systimer`

## Requirements
- R1: After reset the control register reads 0, the value register reads 0 and `irq` is low.
- R2: The control register sits at offset 0x40. Bit 0 is run, bit 1 is interrupt enable, bit 2 is the read-only pending flag, and bit 4 is the clear strobe. Bit 4 and every other unlisted bit read 0. The value register at 0x44 reads the current count, zero-extended. Any other offset reads 0.
- R3: When run is set, writing N to 0x44 loads N and starts the countdown. After N tick cycles the count is 0 and pending is 1. Further ticks leave the count at 0, so there is no reload.
- R4: The count changes only in cycles where `tick_en` is high. Idle cycles hold it.
- R5: A write to 0x44 while run is clear is ignored. The count is unchanged and ticks do not move it.
- R6: In a control write, bits 1 and 4 act only if bit 0 is 1 in that write or run was already set. Otherwise the interrupt enable and pending flag are unchanged.
- R7: A control write that is allowed to act and carries bit 4 = 1 clears pending. If the count expires in the same cycle, pending stays set.
- R8: `irq` equals pending AND interrupt enable. It stays high until a control write clears pending or clears the enable.
- R9: Writing 0 to the control register while running clears run and interrupt enable. It freezes the count and keeps pending.
- R10: A loaded value below MIN_TICKS (3) loads as MIN_TICKS. The all-ones value (truncated to CNT_W bits) loads and counts in full.
- R11: Writing a new value while a countdown runs restarts it from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Count one tick this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with CNT_W = 12 and keeps MIN_TICKS at its default of 3. The narrower counter makes the all-ones timeout only 4095 ticks long. That lets a full-length countdown from the largest value, and its expiry, run to completion. The counter is the same logic at 32 bits. With MIN_TICKS at 3, values of 0 and 1 show the clamp within a few ticks.

// File: rtl/systimer_pkg.sv
package systimer_pkg;
  // Control register bit positions (software-visible layout)
  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_IE_BIT   = 1;
  localparam int unsigned CTL_PEND_BIT = 2;
  localparam int unsigned CTL_CLR_BIT  = 4;
endpackage

// File: rtl/systimer_ctrl.sv
module systimer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,      // control register write this cycle
  input  logic run_bit_i,
  input  logic ie_bit_i,
  input  logic clr_bit_i,
  input  logic done_i,    // countdown expired this cycle
  output logic run_o,
  output logic ie_o,
  output logic pend_o
);
  logic run_q, ie_q, pend_q;
  logic run_d, ie_d, pend_d;
  logic gate;
  logic run_ce, ie_ce, pend_ce;

  assign gate = wr_i & (run_bit_i | run_q);

  always_comb begin
    run_d  = run_bit_i;
    ie_d   = ie_bit_i;
    pend_d = pend_q;
    if (gate && clr_bit_i) pend_d = 1'b0;
    if (done_i)            pend_d = 1'b1;
  end

  assign run_ce  = wr_i;
  assign ie_ce   = gate;
  assign pend_ce = done_i | (gate & clr_bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (run_ce)  run_q  <= run_d;
      if (ie_ce)   ie_q   <= ie_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  assign run_o  = run_q;
  assign ie_o   = ie_q;
  assign pend_o = pend_q;

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && clr_bit_i && !done_i) |=> !pend_q);
  // R6
  ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !run_bit_i && !run_q) |=> $stable(ie_q));
  // R3
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(done_i));
endmodule

// File: rtl/systimer_count.sv
module systimer_count #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MIN_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             cnt_ce, done;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    done   = 1'b0;
    cnt_ce = 1'b0;
    if (load_i) begin
      cnt_d  = (load_val_i < MIN_V) ? MIN_V : load_val_i;
      act_d  = 1'b1;
      cnt_ce = 1'b1;
    end else if (!run_i) begin
      act_d = 1'b0;
    end else if (act_q && tick_i) begin
      cnt_d  = cnt_q - ONE_V;
      cnt_ce = 1'b1;
      if (cnt_q == ONE_V) begin
        act_d = 1'b0;
        done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R10
  min_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q >= MIN_V));
  // R3
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/oneshot_systimer.sv
module oneshot_systimer #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MIN_TICKS = 3,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'('h40),
  parameter logic [ADDR_W-1:0] VALUE_OFS = ADDR_W'('h44)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              irq
);
  import systimer_pkg::*;

  logic             ctl_wr, val_wr, load;
  logic             run, ie, pend, done;
  logic [CNT_W-1:0] cnt;

  assign ctl_wr = bus_we && (bus_addr == CTRL_OFS);
  assign val_wr = bus_we && (bus_addr == VALUE_OFS);
  assign load   = val_wr && run;

  systimer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctl_wr),
    .run_bit_i (bus_wdata[CTL_RUN_BIT]),
    .ie_bit_i  (bus_wdata[CTL_IE_BIT]),
    .clr_bit_i (bus_wdata[CTL_CLR_BIT]),
    .done_i    (done),
    .run_o     (run),
    .ie_o      (ie),
    .pend_o    (pend)
  );

  systimer_count #(
    .CNT_W     (CNT_W),
    .MIN_TICKS (MIN_TICKS)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .tick_i     (tick_en),
    .load_i     (load),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .cnt_o      (cnt),
    .done_o     (done)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[CTL_RUN_BIT]  = run;
      bus_rdata[CTL_IE_BIT]   = ie;
      bus_rdata[CTL_PEND_BIT] = pend;
    end else if (bus_addr == VALUE_OFS) begin
      bus_rdata = DATA_W'(cnt);
    end
  end

  assign irq = pend & ie;

  // R5
  val_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && !run) |=> $stable(cnt));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_wr) |=> irq);
  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && run && bus_wdata == '0) |=> (!run && !ie && $stable(pend)));
endmodule

// File: tb/oneshot_systimer_bench.sv
module oneshot_systimer_bench;
  localparam int unsigned CW = 12;
  localparam logic [7:0] A_CTL = 8'h40;
  localparam logic [7:0] A_VAL = 8'h44;
  localparam int NV = 6;
  // load value, ticks, expected count, expected pending
  localparam int VEC_VAL [NV] = '{10, 1, 0, 3, 20, 7};
  localparam int VEC_TCK [NV] = '{4, 3, 2, 3, 25, 6};
  localparam int VEC_CNT [NV] = '{6, 0, 1, 0, 0, 1};
  localparam int VEC_PND [NV] = '{0, 1, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0;
  logic we = 1'b0;
  logic tick = 1'b0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  oneshot_systimer #(.CNT_W(CW)) u_oneshot_systimer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .tick_en(tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #2; v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CTL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_VAL, d); chk("R1 value", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    // R2 unmapped offset and readback layout
    rd(8'h48, d); chk("R2 unmapped", d, 32'h0);
    wr(A_CTL, 32'hFFFF_FFEB); rd(A_CTL, d); chk("R2 ctrl layout", d, 32'h3);
    wr(A_CTL, 32'h0);

    // R3 R10 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, 32'h11);
      wr(A_VAL, VEC_VAL[i]);
      ticks(VEC_TCK[i]);
      rd(A_VAL, d); chk("R3/R10 vec count", d, VEC_CNT[i]);
      rd(A_CTL, d); chk("R3 vec pending", d, VEC_PND[i] ? 32'h5 : 32'h1);
    end

    // R4 ticks only when tick_en high
    wr(A_CTL, 32'h11); wr(A_VAL, 10);
    ticks(2); repeat (5) @(negedge clk); ticks(1);
    rd(A_VAL, d); chk("R4 gated count", d, 7);

    // R9 stop freezes count
    wr(A_CTL, 32'h03); wr(A_VAL, 100); ticks(10);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); chk("R9 ctrl after stop", d, 32'h0);
    ticks(5); rd(A_VAL, d); chk("R9 frozen count", d, 90);

    // R5 value write while stopped is ignored
    wr(A_VAL, 50); ticks(5);
    rd(A_VAL, d); chk("R5 ignored write", d, 90);

    // R6 gated control bits, R9 pending kept
    wr(A_CTL, 32'h01); wr(A_VAL, 3); ticks(3);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); chk("R9 pending kept", d, 32'h4);
    wr(A_CTL, 32'h12);
    rd(A_CTL, d); chk("R6 ie/clr ignored", d, 32'h4);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
    wr(A_CTL, 32'h11);
    rd(A_CTL, d); chk("R7 clear in same write", d, 32'h1);

    // R8 interrupt level
    wr(A_CTL, 32'h03); wr(A_VAL, 4); ticks(3);
    chk("R8 irq before expiry", {31'b0, irq}, 32'h0);
    ticks(1); #2;
    chk("R8 irq at expiry", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    wr(A_CTL, 32'h01); #2;
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(A_CTL, d); chk("R8 pending while masked", d, 32'h5);
    wr(A_CTL, 32'h03); #2;
    chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
    wr(A_CTL, 32'h13); #2;
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);

    // R11 restart while running
    wr(A_VAL, 50); ticks(10); wr(A_VAL, 5); ticks(4);
    rd(A_CTL, d); chk("R11 not yet expired", d, 32'h3);
    ticks(1);
    rd(A_VAL, d); chk("R11 count", d, 0);
    chk("R11 irq", {31'b0, irq}, 32'h1);
    ticks(10);
    rd(A_VAL, d); chk("R3 no reload", d, 0);

    // R10 largest value
    wr(A_CTL, 32'h11); wr(A_VAL, 32'hFFFF_FFFF);
    rd(A_VAL, d); chk("R10 max load", d, 32'hFFF);
    ticks(4094);
    rd(A_CTL, d); chk("R10 max not expired", d, 32'h1);
    rd(A_VAL, d); chk("R10 max remaining", d, 1);
    ticks(1);
    rd(A_CTL, d); chk("R10 max expired", d, 32'h5);

    summary();
  end
endmodule